// File: doc/BRIEF.md
# Per-Channel Zero Input Detector

This block watches a stereo stream of 24-bit samples and reports, for each channel on its own, when that channel has carried nothing but all-zero samples for a long unbroken run of sample frames. Each channel keeps a run-length counter. The counter advances once per valid frame while the channel's sample is zero. The channel's flag rises once the run reaches the threshold, which is 8192 frames by default.

A single nonzero sample on a channel clears that channel's counter and flag in the same frame. The two channels never affect each other. A test-mode input turns detection off: while it is high, both flags stay low and both counters stay at zero. Downstream logic uses the flags to recognise silence, for example to quiet an output stage. The block only produces the two flag levels and does not drive pins itself.

Top module: `zero_flag_detector`

## Requirements
- R1: The left flag goes high on the clock edge that accepts the ZERO_RUN-th consecutive valid frame whose left sample is zero, meaning all 24 bits are 0. It is low before that edge.
- R2: The right flag follows the rule of R1 using the right sample only. Neither channel's sample has any effect on the other channel's flag.
- R3: A valid frame with a nonzero sample on a channel clears that channel's flag on that edge and restarts its run from zero. Any single set bit counts as nonzero, including bit 0 and bit 23.
- R4: While test_mode is 1, both flags are low at every following edge and both runs restart. After test_mode returns to 0, a flag needs a fresh run of ZERO_RUN zero frames.
- R5: Once a run reaches ZERO_RUN, further zero frames keep the flag high for as long as the silence lasts. The run count never wraps.
- R6: Frames with frame_valid at 0 leave both counters and both flags unchanged. They neither extend a run nor break it.
- R7: While rst_n is sampled low at a clock edge, both flags and both counters clear. A run that was in progress then starts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_valid | input | 1 | The samples on this cycle form one frame |
| left_sample | input | 24 | Left channel sample |
| right_sample | input | 24 | Right channel sample |
| test_mode | input | 1 | Disables detection while high |
| left_zero_flag | output | 1 | Left channel silence flag |
| right_zero_flag | output | 1 | Right channel silence flag |

## Verification
The assertions assume that frame_valid, test_mode and both samples are stable, known levels at each rising clock edge. They also assume each frame is presented for exactly one cycle. The bench meets this by changing every input only on the falling clock edge. It holds reset and test mode for whole cycles, and it interleaves invalid cycles so that they fall inside long zero runs. With this stimulus the hold, clear and saturation properties are exercised at and around the threshold edge.

// File: rtl/zfd_pkg.sv
// Package: shared constants and helpers for the zero flag detector.
// Assumes: channel index 0 is left and index 1 is right.
package zfd_pkg;

    localparam int NUM_CH    = 2;
    localparam int CH_LEFT   = 0;
    localparam int CH_RIGHT  = 1;

    // Classification of one accepted frame for a channel.
    typedef enum logic [1:0] {
        FRAME_NONE    = 2'd0,  // no frame accepted this cycle
        FRAME_ZERO    = 2'd1,  // accepted frame, sample all zero
        FRAME_SIGNAL  = 2'd2,  // accepted frame, sample nonzero
        FRAME_BLOCKED = 2'd3   // detection disabled by test mode
    } frame_kind_e;

endpackage

// File: rtl/zfd_zero_cmp.sv
// Module: zfd_zero_cmp
// Reduces one sample to a single "all bits zero" indication.
// Assumes: the sample is a plain bit vector; its sign has no meaning here.
module zfd_zero_cmp #(
    parameter int SAMPLE_W = 24
) (
    input  logic [SAMPLE_W-1:0] sample_i,
    output logic                is_zero_o
);

    // Purpose: a NOR over every bit of the sample.
    always_comb begin
        is_zero_o = ~(|sample_i);
    end

endmodule

// File: rtl/zfd_frame_class.sv
// Module: zfd_frame_class
// Sorts each cycle for one channel into the frame kinds of zfd_pkg.
// Assumes: test mode takes priority over validity, and validity takes priority over data.
module zfd_frame_class
    import zfd_pkg::*;
(
    input  logic        frame_valid_i,
    input  logic        test_mode_i,
    input  logic        is_zero_i,
    output frame_kind_e kind_o
);

    // Purpose: priority decode of test mode, validity and sample content.
    always_comb begin
        if (test_mode_i) begin
            kind_o = FRAME_BLOCKED;
        end else if (!frame_valid_i) begin
            kind_o = FRAME_NONE;
        end else if (is_zero_i) begin
            kind_o = FRAME_ZERO;
        end else begin
            kind_o = FRAME_SIGNAL;
        end
    end

endmodule

// File: rtl/zfd_run_counter.sv
// Module: zfd_run_counter
// Counts consecutive zero frames for one channel, saturating at ZERO_RUN.
// The flag is registered and rises when the count reaches ZERO_RUN.
// Assumes: kind_i is stable at the rising edge; the reset is synchronous and active low.
module zfd_run_counter
    import zfd_pkg::*;
#(
    parameter int ZERO_RUN = 8192,
    localparam int CNT_W   = $clog2(ZERO_RUN + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  frame_kind_e kind_i,
    output logic        flag_o
);

    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(ZERO_RUN);

    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] run_d;
    logic             flag_d;

    // Purpose: next count, either saturating increment, hold or restart.
    always_comb begin
        run_d = run_q;
        unique case (kind_i)
            FRAME_ZERO:    run_d = (run_q == CNT_TOP) ? run_q : run_q + 1'b1;
            FRAME_SIGNAL:  run_d = '0;
            FRAME_BLOCKED: run_d = '0;
            default:       run_d = run_q;
        endcase
        flag_d = (run_d == CNT_TOP);
    end

    // Purpose: state registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            flag_o <= 1'b0;
        end else begin
            run_q  <= run_d;
            flag_o <= flag_d;
        end
    end

    // Assertions guarding the counter.
    p_rise_at_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == FRAME_ZERO && run_q == CNT_TOP - 1'b1) |=> flag_o);

    p_signal_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == FRAME_SIGNAL) |=> (!flag_o && run_q == '0));

    p_test_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == FRAME_BLOCKED) |=> (!flag_o && run_q == '0));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= CNT_TOP);

    p_stay_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && kind_i == FRAME_ZERO) |=> flag_o);

    p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == FRAME_NONE) |=> ($stable(run_q) && $stable(flag_o)));

    p_reset_clear_r7: assert property (@(posedge clk)
        !rst_n |=> (!flag_o && run_q == '0));

endmodule

// File: rtl/zero_flag_detector.sv
// Module: zero_flag_detector (top)
// Two independent zero-run detectors, one for the left channel and one for the right.
// Assumes: one frame per cycle in which frame_valid is high; inputs are synchronous to clk.
module zero_flag_detector
    import zfd_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int ZERO_RUN = 8192
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_valid,
    input  logic [SAMPLE_W-1:0] left_sample,
    input  logic [SAMPLE_W-1:0] right_sample,
    input  logic                test_mode,
    output logic                left_zero_flag,
    output logic                right_zero_flag
);

    logic [SAMPLE_W-1:0] ch_sample [NUM_CH];
    logic [NUM_CH-1:0]   ch_zero;
    frame_kind_e         ch_kind   [NUM_CH];
    logic [NUM_CH-1:0]   ch_flag;

    // Purpose: gather the channel samples into an indexed array.
    always_comb begin
        ch_sample[CH_LEFT]  = left_sample;
        ch_sample[CH_RIGHT] = right_sample;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        zfd_zero_cmp #(.SAMPLE_W(SAMPLE_W)) u_cmp (
            .sample_i  (ch_sample[c]),
            .is_zero_o (ch_zero[c])
        );

        zfd_frame_class u_cls (
            .frame_valid_i (frame_valid),
            .test_mode_i   (test_mode),
            .is_zero_i     (ch_zero[c]),
            .kind_o        (ch_kind[c])
        );

        zfd_run_counter #(.ZERO_RUN(ZERO_RUN)) u_run (
            .clk    (clk),
            .rst_n  (rst_n),
            .kind_i (ch_kind[c]),
            .flag_o (ch_flag[c])
        );
    end

    // Purpose: route the per-channel flags to the named outputs.
    always_comb begin
        left_zero_flag  = ch_flag[CH_LEFT];
        right_zero_flag = ch_flag[CH_RIGHT];
    end

    // R2: a nonzero right sample in a valid frame forces the right flag low, whatever the left does.
    p_right_indep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && !test_mode && right_sample != '0) |=> !right_zero_flag);

endmodule

// File: tb/zero_flag_detector_tb_top.sv
module zero_flag_detector_tb_top;

    localparam int THR = 8192;
    localparam int SW  = 24;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          valid;
    logic          tmode;
    logic [SW-1:0] ls;
    logic [SW-1:0] rs;
    logic          lf;
    logic          rf;

    int    total = 0;
    int    bad   = 0;
    string phase = "R7";
    int    mcnt[2];
    bit    mflag[2];
    bit    finished = 0;

    always #10 clk = ~clk;

    zero_flag_detector #(.SAMPLE_W(SW), .ZERO_RUN(THR)) dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .frame_valid     (valid),
        .left_sample     (ls),
        .right_sample    (rs),
        .test_mode       (tmode),
        .left_zero_flag  (lf),
        .right_zero_flag (rf)
    );

    task automatic check(string req, string what, logic act, bit exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference: run length per channel from the requirements.
    task automatic model_edge();
        logic [SW-1:0] s;
        for (int ch = 0; ch < 2; ch++) begin
            s = (ch == 0) ? ls : rs;
            if (!rst_n || tmode) begin
                mcnt[ch]  = 0;
                mflag[ch] = 0;
            end else if (valid) begin
                if (s == '0) begin
                    if (mcnt[ch] < THR) mcnt[ch]++;
                    mflag[ch] = (mcnt[ch] >= THR);
                end else begin
                    mcnt[ch]  = 0;
                    mflag[ch] = 0;
                end
            end
        end
    endtask

    // Drive one cycle (called at a falling edge), update the model, compare at the next falling edge.
    task automatic cycle(bit r, bit v, logic [SW-1:0] l, logic [SW-1:0] rr, bit t);
        rst_n = r; valid = v; ls = l; rs = rr; tmode = t;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(phase, "left flag", lf, mflag[0]);
        check(phase, "right flag", rf, mflag[1]);
    endtask

    initial begin
        rst_n = 1'b0; valid = 1'b0; tmode = 1'b0; ls = '0; rs = '0;
        mcnt[0] = 0; mcnt[1] = 0; mflag[0] = 0; mflag[1] = 0;
        @(negedge clk);

        // R7: reset state
        phase = "R7";
        for (int i = 0; i < 3; i++) cycle(0, 1, '0, '0, 0);

        // R1 with R6 gaps: left silent, right busy, some invalid frames
        phase = "R1/R6";
        for (int i = 0; i < THR + 40; i++) cycle(1, (i % 7) != 3, '0, 24'h000123, 0);

        // R5: long silence keeps the flag and does not wrap
        phase = "R5";
        for (int i = 0; i < THR + 50; i++) cycle(1, 1, '0, 24'h000123, 0);

        // R3: lowest bit, then MSB, clear the left flag
        phase = "R3";
        cycle(1, 1, 24'h000001, 24'h000123, 0);
        for (int i = 0; i < 10; i++) cycle(1, 1, '0, 24'h000123, 0);
        cycle(1, 1, 24'h800000, 24'h000123, 0);

        // R2: right silent alone
        phase = "R2";
        for (int i = 0; i < THR + 5; i++) cycle(1, 1, 24'h7FFFFF, '0, 0);
        phase = "R3";
        cycle(1, 1, 24'h7FFFFF, 24'h400000, 0);
        cycle(1, 0, 24'h7FFFFF, '0, 0);

        // R4: test mode quiets both, then a fresh run is needed
        phase = "R4";
        for (int i = 0; i < THR + 5; i++) cycle(1, 1, '0, '0, 0);
        for (int i = 0; i < 4; i++) cycle(1, 1, '0, '0, 1);
        for (int i = 0; i < THR - 1; i++) cycle(1, 1, '0, '0, 0);
        cycle(1, 1, '0, '0, 0);
        cycle(1, 1, '0, '0, 0);

        // R7: reset in the middle of a run
        phase = "R7";
        for (int i = 0; i < 100; i++) cycle(1, 1, '0, '0, 0);
        cycle(0, 1, '0, '0, 0);
        cycle(0, 1, '0, '0, 0);
        for (int i = 0; i < THR + 2; i++) cycle(1, 1, '0, '0, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog all actual=timeout expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule